// File: doc/BRIEF.md
# Two-Cell Overcharge Charge-Path Controller

This block decides whether the charge switch of a two-cell battery pack may stay on. Analog comparators outside the block reduce each cell's voltage to two digital flags: one says the cell has reached the overcharge trip level, and one says the cell has fallen back to the release level. Three further flags report the pack's load node: whether it sits above the overcurrent level, whether a load is attached, and whether an excessive-voltage charger has been detected. A millisecond tick paces all timing. A test-mode pin shortens every delay.

When a cell stays at the trip level for a full detection window, the block latches the overcharge state and drops the charge enable. While that state is latched, it tells the discharge-side controller to ignore its overcurrent comparator, though not its short-circuit comparator. It also asks the cell comparator for the narrower release hysteresis once a load has been seen. The charge enable returns after a shorter release window in which every release condition holds. All pins are plain level control and status signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `ochg_chg_ctrl`

## Requirements
- R1: After reset, and again after any later reset, `chg_en` is 1, `ovc_mask` is 0, `hyst_sel` is 0, and both delay counters are clear.
- R2: In the normal state, if `cell_hi` (bit 0 = lower cell, bit 1 = upper cell) has any bit set on DET_MS consecutive `ms_tick` pulses, `chg_en` falls at the clock edge that samples the DET_MS-th pulse and not before. The default for DET_MS is 1000.
- R3: If `cell_hi` returns to 00 before the detection window completes, the detection count clears. A later detection then needs a full new window.
- R4: In the latched state, a release pulse is one where all of the following hold: `cell_rel_ok` is 11, `vm_over_oc` is 0 or `load_present` is 1, and `xchg_det` is 0. After REL_MS release pulses in a row (default 40), `chg_en` rises at the edge that samples the last one.
- R5: If `vm_over_oc` and `load_present` are both 1 while either cell still has `cell_rel_ok` at 0, `chg_en` stays 0. If `vm_over_oc` is 1 with no load attached, `chg_en` also stays 0.
- R6: If any release condition drops before the release window completes, the release count clears.
- R7: While `xchg_det` is 1, the latched state is never released.
- R8: `ovc_mask` is 1 exactly while the overcharge state is latched, which is whenever `chg_en` is 0.
- R9: `hyst_sel` becomes 1 on the first clock in the latched state at which `load_present` is 1. It stays 1 until release. It is never 1 in the normal state.
- R10: With `test_mode` at 1, the detection window is DET_MS/TEST_DIV pulses and the release window is max(1, REL_MS/TEST_DIV) pulses. With the defaults these are 15 and 1.
- R11: The state changes only at an edge where `ms_tick` is 1. Without ticks, `chg_en` holds whatever the flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| test_mode | input | 1 | 1 = shortened delays, 0 = normal delays |
| cell_hi | input | 2 | Per-cell flag: at or above the overcharge trip level |
| cell_rel_ok | input | 2 | Per-cell flag: at or below the release level |
| vm_over_oc | input | 1 | Load node above the overcurrent level |
| load_present | input | 1 | A load is connected |
| xchg_det | input | 1 | Excessive-voltage charger detected |
| chg_en | output | 1 | Charge switch enable |
| ovc_mask | output | 1 | Tells the discharge side to ignore overcurrent |
| hyst_sel | output | 1 | Selects the reduced release hysteresis |

## Verification
The bound checker checks several rules on every cycle. A fall of the charge enable must follow a tick with a cell at the trip level. A rise must follow a tick on which every release condition held. Nothing moves without a tick. An excessive charger holds the latch. The mask and hysteresis select stay consistent with the latched state. The exact window lengths and the clearing of a partly counted window can only be shown by the bench's scenarios. The same holds for the shortened test-mode windows and the blocking combinations of load node and load.

// File: rtl/ochg_pkg.sv
package ochg_pkg;
  typedef enum logic {ST_NORMAL = 1'b0, ST_LATCHED = 1'b1} ochg_state_t;

  function automatic int unsigned short_count(input int unsigned full, input int unsigned div);
    int unsigned q;
    q = full / div;
    return (q == 0) ? 1 : q;
  endfunction
endpackage

// File: rtl/ochg_window_timer.sv
module ochg_window_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign done     = run && tick && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || done)   cnt <= '0;
    else if (tick)           cnt <= next_cnt[CW-1:0];
  end
endmodule

// File: rtl/ochg_release_gate.sv
module ochg_release_gate (
  input  logic [1:0] cell_rel_ok,
  input  logic       vm_over_oc,
  input  logic       load_present,
  input  logic       xchg_det,
  output logic       rel_ok
);
  logic cells_low;
  logic node_ok;

  assign cells_low = &cell_rel_ok;
  assign node_ok   = !vm_over_oc || load_present;
  assign rel_ok    = cells_low && node_ok && !xchg_det;
endmodule

// File: rtl/ochg_chg_ctrl.sv
module ochg_chg_ctrl
  import ochg_pkg::*;
#(
  parameter int unsigned DET_MS   = 1000,
  parameter int unsigned REL_MS   = 40,
  parameter int unsigned TEST_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       test_mode,
  input  logic [1:0] cell_hi,
  input  logic [1:0] cell_rel_ok,
  input  logic       vm_over_oc,
  input  logic       load_present,
  input  logic       xchg_det,
  output logic       chg_en,
  output logic       ovc_mask,
  output logic       hyst_sel
);
  localparam int unsigned MAXW   = (DET_MS > REL_MS) ? DET_MS : REL_MS;
  localparam int unsigned CW     = $clog2(MAXW + 1);
  localparam int unsigned DET_T  = short_count(DET_MS, TEST_DIV);
  localparam int unsigned REL_T  = short_count(REL_MS, TEST_DIV);

  ochg_state_t   state;
  logic          det_run, rel_run, det_done, rel_done, rel_ok;
  logic          hyst_q;
  logic [CW-1:0] det_lim, rel_lim;

  assign det_lim = test_mode ? CW'(DET_T) : CW'(DET_MS);
  assign rel_lim = test_mode ? CW'(REL_T) : CW'(REL_MS);

  ochg_release_gate u_gate (
    .cell_rel_ok  (cell_rel_ok),
    .vm_over_oc   (vm_over_oc),
    .load_present (load_present),
    .xchg_det     (xchg_det),
    .rel_ok       (rel_ok)
  );

  assign det_run = (state == ST_NORMAL)  && (|cell_hi);
  assign rel_run = (state == ST_LATCHED) && rel_ok;

  ochg_window_timer #(.CW(CW)) u_det (
    .clk (clk), .rst_n (rst_n), .run (det_run), .tick (ms_tick),
    .limit (det_lim), .done (det_done)
  );

  ochg_window_timer #(.CW(CW)) u_rel (
    .clk (clk), .rst_n (rst_n), .run (rel_run), .tick (ms_tick),
    .limit (rel_lim), .done (rel_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_NORMAL;
      hyst_q <= 1'b0;
    end else begin
      case (state)
        ST_NORMAL: begin
          hyst_q <= 1'b0;
          if (det_done) state <= ST_LATCHED;
        end
        default: begin
          if (rel_done) begin
            state  <= ST_NORMAL;
            hyst_q <= 1'b0;
          end else if (load_present) begin
            hyst_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign chg_en   = (state == ST_NORMAL);
  assign ovc_mask = (state == ST_LATCHED);
  assign hyst_sel = hyst_q;
endmodule

// File: rtl/ochg_chg_ctrl_chk.sv
module ochg_chg_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic [1:0] cell_hi,
  input logic [1:0] cell_rel_ok,
  input logic       vm_over_oc,
  input logic       load_present,
  input logic       xchg_det,
  input logic       chg_en,
  input logic       ovc_mask,
  input logic       hyst_sel
);
  p_fall_needs_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_en) |-> ($past(ms_tick) && ($past(cell_hi) != 2'b00)));

  p_rise_needs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_en) |-> ($past(ms_tick) && ($past(cell_rel_ok) == 2'b11) &&
                       (!$past(vm_over_oc) || $past(load_present)) && !$past(xchg_det)));

  p_xchg_holds_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && xchg_det) |=> !chg_en);

  p_mask_tracks_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_mask != chg_en);

  p_hyst_only_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hyst_sel |-> !chg_en);

  p_no_tick_no_move_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(chg_en));
endmodule

bind ochg_chg_ctrl ochg_chg_ctrl_chk u_chk (
  .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .cell_hi (cell_hi),
  .cell_rel_ok (cell_rel_ok), .vm_over_oc (vm_over_oc),
  .load_present (load_present), .xchg_det (xchg_det),
  .chg_en (chg_en), .ovc_mask (ovc_mask), .hyst_sel (hyst_sel)
);

// File: tb/tb_ochg_chg_ctrl.sv
module tb_ochg_chg_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, test_mode = 1'b0;
  logic [1:0] cell_hi = 2'b00, cell_rel_ok = 2'b11;
  logic vm_over_oc = 1'b0, load_present = 1'b0, xchg_det = 1'b0;
  logic chg_en, ovc_mask, hyst_sel;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  ochg_chg_ctrl dut (
    .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .test_mode (test_mode),
    .cell_hi (cell_hi), .cell_rel_ok (cell_rel_ok), .vm_over_oc (vm_over_oc),
    .load_present (load_present), .xchg_det (xchg_det),
    .chg_en (chg_en), .ovc_mask (ovc_mask), .hyst_sel (hyst_sel)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  hi;
    logic [1:0]  rok;
    logic        vm;
    logic        ld;
    logic        xc;
    logic        tm;
    logic [10:0] n;
    logic        en;
    logic        msk;
    logic        hs;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5,   1'b1, 1'b0, 1'b0}, // R1 idle
    '{4'd2,  2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 11'd999, 1'b1, 1'b0, 1'b0}, // R2 one short
    '{4'd3,  2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1,   1'b1, 1'b0, 1'b0}, // R3 abort
    '{4'd3,  2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 11'd999, 1'b1, 1'b0, 1'b0}, // R3 restarted
    '{4'd2,  2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 11'd1,   1'b0, 1'b1, 1'b0}, // R2 trips
    '{4'd4,  2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 11'd100, 1'b0, 1'b1, 1'b0}, // R4 one cell
    '{4'd5,  2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 11'd100, 1'b0, 1'b1, 1'b0}, // R5 no load
    '{4'd5,  2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 11'd100, 1'b0, 1'b1, 1'b1}, // R5 cell high
    '{4'd9,  2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 11'd39,  1'b0, 1'b1, 1'b1}, // R9 held
    '{4'd6,  2'b00, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 11'd1,   1'b0, 1'b1, 1'b1}, // R6 abort
    '{4'd6,  2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 11'd39,  1'b0, 1'b1, 1'b1}, // R6 restarted
    '{4'd4,  2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 11'd1,   1'b1, 1'b0, 1'b0}, // R4 release
    '{4'd10, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 11'd14,  1'b1, 1'b0, 1'b0}, // R10 short det
    '{4'd10, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 11'd1,   1'b0, 1'b1, 1'b0}, // R10 trips
    '{4'd7,  2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 11'd10,  1'b0, 1'b1, 1'b0}, // R7 blocked
    '{4'd10, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 11'd1,   1'b1, 1'b0, 1'b0}, // R10 release
    '{4'd8,  2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 11'd3,   1'b1, 1'b0, 1'b0}  // R8 mask low
  };

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic check_all(input string tag, input logic e, input logic m, input logic h);
    check(tag, chg_en, e, "chg_en");
    check(tag, ovc_mask, m, "ovc_mask");
    check(tag, hyst_sel, h, "hyst_sel");
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset", 1'b1, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      cell_hi = VECS[v].hi;  cell_rel_ok = VECS[v].rok; vm_over_oc = VECS[v].vm;
      load_present = VECS[v].ld; xchg_det = VECS[v].xc; test_mode = VECS[v].tm;
      @(negedge clk);
      pulses(int'(VECS[v].n));
      check_all($sformatf("R%0d row%0d", VECS[v].req, v), VECS[v].en, VECS[v].msk, VECS[v].hs);
    end

    // R11: trip level held without ticks, then reset while latched (R1)
    test_mode = 1'b1; cell_hi = 2'b01; cell_rel_ok = 2'b00;
    repeat (2000) @(negedge clk);
    check("R11 no ticks", chg_en, 1'b1, "chg_en");
    pulses(15);
    load_present = 1'b1;
    @(negedge clk);
    check_all("R9 latched with load", 1'b0, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cell_hi = 2'b00; load_present = 1'b0;
    @(negedge clk);
    check_all("R1 reset while latched", 1'b1, 1'b0, 1'b0);
    // R1: detection counter cleared by reset (14 ticks must not trip)
    cell_hi = 2'b10;
    pulses(14);
    check("R1 counter cleared", chg_en, 1'b1, "chg_en");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule